// File: doc/BRIEF.md
# Plesiochronous Four-Tributary Frame Multiplexer

The block combines four low-rate NRZ tributaries into one high-rate NRZ frame. A mode pin picks one of two frame sizes: 848 bits for four 2 Mbit/s tributaries into one 8 Mbit/s stream, or 1536 bits for four 8 Mbit/s tributaries into one 34 Mbit/s stream. Each tributary goes into a small elastic store. Once per frame the block decides, per tributary, whether to stuff. It then writes the alignment word, two flag bits, the stuffing control bits and the interleaved payload.

Tributary bits arrive as single-cycle write strobes in the high-speed clock domain. Clock recovery and synchronisation are done upstream. A line cannot be stalled, so the inputs carry valid only: a write into a full store is dropped and reported. The output side is valid/ready. out_valid is high in every cycle after reset. A bit is transferred in each cycle where out_ready is high. While out_ready is low, the frame position and the store read pointers do not move.

A tributary can be switched into flag mode. In that mode it is never stuffed, and its justification opportunity bit carries a software-chosen flag bit instead of payload.

Top module: `ptm_frame_mux`

## Requirements
- R1: `mode` is sampled when the first bit of a frame is transferred. A frame is 848 transfers long when that sample is 0 and 1536 transfers long when it is 1. A change of `mode` in the middle of a frame takes effect at the next frame.
- R2: `out_sync` is high only while the first frame bit is presented. Frame bits 0 to 9 are the alignment word 1,1,1,1,0,1,0,0,0,0.
- R3: Frame bit 10 is `alarm_bit` and frame bit 11 is `national_bit`, both taken while the bit is presented.
- R4: The frame has four sets of equal length S, with S = 212 or 384. Set 1 payload starts at offset 12. Sets 2 and 3 payload starts at offset 4. Set 4 payload starts at offset 8. Each payload bit belongs to tributary (offset mod 4), so a tributary gets 205 (or 377) payload bits per frame, plus its opportunity bit when that bit is not stuffed.
- R5: Tributary j is stuffed when its store holds fewer than DEPTH/2 bits in the cycle the first frame bit is transferred and its `aux_en[j]` is 0. Offset j of sets 2, 3 and 4 is 1 when the tributary is stuffed and 0 when it is not.
- R6: Opportunity bit j is at set 4, offset 4+j. If `aux_en[j]` was 1 at frame start, it carries `aux_bit[j]`. Otherwise it is 0 when stuffed, and the next store bit of tributary j when not stuffed.
- R7: While `force_ais[j]` is 1, every payload and opportunity-data bit of tributary j is output as 1, and its store is still read as normal.
- R8: A write to a full store is dropped unless the same store is read in that cycle. A dropped write raises `es_alarm[j]` for one cycle in the next cycle.
- R9: A read of an empty store outputs 1, leaves the store unchanged and raises `es_alarm[j]` for one cycle in the next cycle.
- R10: `out_valid` is 1 from the first cycle after reset. While `out_ready` is 0, the frame position, the stuffing decisions and the store contents (other than writes) do not change.
- R11: During reset, `out_valid`, `out_sync` and `es_alarm` are 0, and the frame restarts at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0: 848-bit frame, 1: 1536-bit frame |
| trib_valid | input | 4 | Per-tributary write strobe |
| trib_data | input | 4 | Per-tributary data bit |
| force_ais | input | 4 | Replace tributary payload with ones |
| aux_en | input | 4 | Use opportunity bit as flag channel |
| aux_bit | input | 4 | Flag bit for each opportunity slot |
| alarm_bit | input | 1 | Alarm flag bit value |
| national_bit | input | 1 | National flag bit value |
| out_valid | output | 1 | Output bit valid |
| out_ready | input | 1 | Sink accepts output bit |
| out_data | output | 1 | High-speed NRZ data |
| out_sync | output | 1 | Marks first alignment bit |
| es_alarm | output | 4 | Per-tributary store overflow/underflow pulse |

## Verification
Two things can hit the same store in one cycle: a write arriving while the store is full, and a read for a payload bit of that same tributary. The bench forces a tributary's write strobe high in every cycle. The store fills, and from then on writes meet full-store reads at the interleave rate, with the output randomly stalled. A bit-accurate queue model in the bench sets the rule: such a write is kept and raises no alarm, while a write to a full store in a cycle with no read raises an alarm. Every later output bit of that tributary shows whether the right bits were kept.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  localparam int NT = 4;
  localparam logic [9:0] ALIGN_WORD = 10'b1111010000;

  typedef enum logic [2:0] {
    FLD_ALIGN,
    FLD_ALARM,
    FLD_NATIONAL,
    FLD_CTRL,
    FLD_OPP,
    FLD_DATA
  } fld_e;
endpackage

// File: rtl/ptm_elastic_store.sv
module ptm_elastic_store #(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr,
  input  logic                         wdata,
  input  logic                         rd,
  output logic                         rdata,
  output logic [$clog2(DEPTH+1)-1:0]   fill,
  output logic                         ovf,
  output logic                         udf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] mem;
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_rd, do_wr;

  assign do_rd = rd && (cnt != '0);
  assign do_wr = wr && ((cnt != CW'(DEPTH)) || do_rd);
  assign ovf   = wr && !do_wr;
  assign udf   = rd && (cnt == '0);
  assign rdata = mem[rp];
  assign fill  = cnt;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
      cnt <= cnt + CW'(do_wr) - CW'(do_rd);
    end
  end

  a_r8_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH) && wr && !rd) |=> (cnt == CW'(DEPTH)));
  a_r9_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && rd && !wr) |=> (cnt == '0) && $stable(rp));
endmodule

// File: rtl/ptm_frame_seq.sv
module ptm_frame_seq
  import ptm_pkg::*;
#(
  parameter int SET_E2 = 212,
  parameter int SET_E3 = 384
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       mode,
  output fld_e       fld,
  output logic [1:0] lane,
  output logic       first,
  output logic       align_bit
);
  localparam int OW = $clog2(SET_E3 + 1);

  logic [OW-1:0] off;
  logic [1:0]    set_idx;
  logic          mode_q;
  logic [OW-1:0] last_off;
  logic [15:0]   word_ext;

  assign last_off  = mode_q ? OW'(SET_E3 - 1) : OW'(SET_E2 - 1);
  assign first     = (set_idx == 2'd0) && (off == '0);
  assign lane      = off[1:0];
  assign word_ext  = {6'b0, ALIGN_WORD};
  assign align_bit = word_ext[4'd9 - off[3:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off     <= '0;
      set_idx <= '0;
      mode_q  <= 1'b0;
    end else if (adv) begin
      if (first) mode_q <= mode;
      if (off == last_off) begin
        off     <= '0;
        set_idx <= set_idx + 2'd1;
      end else begin
        off <= off + 1'b1;
      end
    end
  end

  always_comb begin
    if (set_idx == 2'd0) begin
      if (off < OW'(10))       fld = FLD_ALIGN;
      else if (off == OW'(10)) fld = FLD_ALARM;
      else if (off == OW'(11)) fld = FLD_NATIONAL;
      else                     fld = FLD_DATA;
    end else begin
      if (off < OW'(4))                            fld = FLD_CTRL;
      else if (set_idx == 2'd3 && off < OW'(8))    fld = FLD_OPP;
      else                                         fld = FLD_DATA;
    end
  end

  a_r1_off_range: assert property (@(posedge clk) disable iff (!rst_n)
    off <= last_off);
  a_r10_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(off) && $stable(set_idx) && $stable(mode_q));
endmodule

// File: rtl/ptm_frame_mux.sv
module ptm_frame_mux
  import ptm_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int SET_E2 = 212,
  parameter int SET_E3 = 384
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode,
  input  logic [3:0] trib_valid,
  input  logic [3:0] trib_data,
  input  logic [3:0] force_ais,
  input  logic [3:0] aux_en,
  input  logic [3:0] aux_bit,
  input  logic       alarm_bit,
  input  logic       national_bit,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       out_data,
  output logic       out_sync,
  output logic [3:0] es_alarm
);
  localparam int CW = $clog2(DEPTH + 1);

  fld_e          fld;
  logic [1:0]    lane;
  logic          first, align_bit, adv;
  logic [NT-1:0] stuff_q, aux_q, data_bit, ovf_v, udf_v, rd_v;
  logic [CW-1:0] fill_v [NT];

  assign adv = out_valid && out_ready;

  ptm_frame_seq #(.SET_E2(SET_E2), .SET_E3(SET_E3)) u_seq (
    .clk(clk), .rst_n(rst_n), .adv(adv), .mode(mode),
    .fld(fld), .lane(lane), .first(first), .align_bit(align_bit)
  );

  for (genvar j = 0; j < NT; j++) begin : g_trib
    logic rdata;
    assign rd_v[j] = adv && (lane == 2'(j)) &&
                     ((fld == FLD_DATA) ||
                      (fld == FLD_OPP && !stuff_q[j] && !aux_q[j]));

    ptm_elastic_store #(.DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr(trib_valid[j]), .wdata(trib_data[j]),
      .rd(rd_v[j]), .rdata(rdata), .fill(fill_v[j]),
      .ovf(ovf_v[j]), .udf(udf_v[j])
    );

    assign data_bit[j] = force_ais[j] || (fill_v[j] == '0) || rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      stuff_q   <= '0;
      aux_q     <= '0;
      es_alarm  <= '0;
    end else begin
      out_valid <= 1'b1;
      es_alarm  <= ovf_v | udf_v;
      if (adv && first) begin
        aux_q <= aux_en;
        for (int k = 0; k < NT; k++)
          stuff_q[k] <= (fill_v[k] < CW'(DEPTH / 2)) && !aux_en[k];
      end
    end
  end

  always_comb begin
    unique case (fld)
      FLD_ALIGN:    out_data = align_bit;
      FLD_ALARM:    out_data = alarm_bit;
      FLD_NATIONAL: out_data = national_bit;
      FLD_CTRL:     out_data = stuff_q[lane];
      FLD_OPP:      out_data = aux_q[lane] ? aux_bit[lane]
                             : (stuff_q[lane] ? 1'b0 : data_bit[lane]);
      default:      out_data = data_bit[lane];
    endcase
  end

  assign out_sync = out_valid && first;

  a_r2_sync_on_align: assert property (@(posedge clk) disable iff (!rst_n)
    out_sync |-> (fld == FLD_ALIGN) && out_data);
  a_r5_no_stuff_in_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && first) |=> ((stuff_q & aux_q) == '0));
  a_r7_ais_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && fld == FLD_DATA && force_ais[lane]) |-> out_data);
  a_r10_valid_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid);
  a_r5_decision_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv && first) |=> $stable(stuff_q) && $stable(aux_q));
endmodule

// File: tb/tb_ptm_frame_mux.sv
`timescale 1ns/1ps
module tb_ptm_frame_mux;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic mode = 0, alarm_bit = 0, national_bit = 0, out_ready = 0;
  logic [3:0] trib_valid = 0, trib_data = 0, force_ais = 0, aux_en = 0, aux_bit = 0;
  logic out_valid, out_data, out_sync;
  logic [3:0] es_alarm;

  ptm_frame_mux #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .trib_valid(trib_valid),
    .trib_data(trib_data), .force_ais(force_ais), .aux_en(aux_en),
    .aux_bit(aux_bit), .alarm_bit(alarm_bit), .national_bit(national_bit),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sync(out_sync), .es_alarm(es_alarm)
  );

  int errs = 0, checks = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errs++;
      if (errs <= 30)
        $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // bench model state
  bit q[4][$];
  int m_off = 0, m_set = 0, xf = 0, exp_len = 0, step_no = 0;
  bit m_mode = 0, seen_first = 0, gaps = 0, hold_low = 0;
  bit [3:0] m_stuff = 0, m_aux = 0, exp_alarm = 0, flood = 0, starve = 0;
  bit [15:0] lfsr = 16'hACE1;
  int num[4], den = 8480, acc[4];
  int ovf_cnt = 0, udf_cnt = 0, stuffed_seen = 0, plain_seen = 0;
  int len848 = 0, len1536 = 0;
  string alm_tag[4];

  function automatic int slen(bit md);
    return md ? 384 : 212;
  endfunction

  task automatic step();
    int fld, ln, popj, sz[4];
    bit expb, adv, hd;
    string tag;
    @(negedge clk);
    for (int j = 0; j < 4; j++)
      chk(es_alarm[j] == exp_alarm[j], alm_tag[j], es_alarm[j], exp_alarm[j], "store alarm");
    // drive inputs
    step_no++;
    out_ready = !(hold_low || (gaps && (step_no % 13 == 5)));
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    trib_data = lfsr[3:0];
    for (int j = 0; j < 4; j++) begin
      trib_valid[j] = 1'b0;
      if (flood[j]) trib_valid[j] = 1'b1;
      else if (!starve[j] && out_ready) begin
        acc[j] += num[j];
        if (acc[j] >= den) begin acc[j] -= den; trib_valid[j] = 1'b1; end
      end
    end
    #1;
    // expected output from requirement layout
    ln = m_off % 4;
    if (m_set == 0) fld = (m_off < 10) ? 0 : (m_off == 10) ? 1 : (m_off == 11) ? 2 : 5;
    else fld = (m_off < 4) ? 3 : (m_set == 3 && m_off < 8) ? 4 : 5;
    hd = force_ais[ln] ? 1'b1 : (q[ln].size() == 0 ? 1'b1 : q[ln][0]);
    case (fld)
      0: begin expb = (m_off < 4) || (m_off == 5); tag = "R2"; end
      1: begin expb = alarm_bit; tag = "R3"; end
      2: begin expb = national_bit; tag = "R3"; end
      3: begin expb = m_stuff[ln]; tag = "R5"; end
      4: begin expb = m_aux[ln] ? aux_bit[ln] : (m_stuff[ln] ? 1'b0 : hd); tag = "R6"; end
      default: begin expb = hd; tag = force_ais[ln] ? "R7" : "R4"; end
    endcase
    if (!out_ready) tag = "R10";
    chk(out_valid == 1'b1, "R10", out_valid, 1, "out_valid");
    chk(out_data == expb, tag, out_data, expb, "out_data");
    chk(out_sync == (m_set == 0 && m_off == 0), "R2", out_sync, (m_set == 0 && m_off == 0), "out_sync");
    if (fld == 3 && m_set == 1 && !m_aux[ln]) begin
      if (m_stuff[ln]) stuffed_seen++; else plain_seen++;
    end
    // model the clock edge
    adv = out_ready;
    popj = -1;
    if (adv && (fld == 5 || (fld == 4 && !m_aux[ln] && !m_stuff[ln]))) popj = ln;
    for (int j = 0; j < 4; j++) sz[j] = q[j].size();
    for (int j = 0; j < 4; j++) begin
      bit uf, of;
      uf = (popj == j) && (sz[j] == 0);
      of = 1'b0;
      if (popj == j && sz[j] > 0) void'(q[j].pop_front());
      if (trib_valid[j]) begin
        if (sz[j] < DEPTH || (popj == j && sz[j] > 0)) q[j].push_back(trib_data[j]);
        else of = 1'b1;
      end
      exp_alarm[j] = uf | of;
      alm_tag[j] = of ? "R8" : "R9";
      if (of) ovf_cnt++;
      if (uf) udf_cnt++;
    end
    if (adv && m_set == 0 && m_off == 0) begin
      if (seen_first) begin
        chk(xf == exp_len, "R1", xf, exp_len, "frame length");
        if (exp_len == 848) len848++;
        if (exp_len == 1536) len1536++;
      end
      seen_first = 1;
      xf = 1;
      for (int j = 0; j < 4; j++) m_stuff[j] = (sz[j] < DEPTH / 2) && !aux_en[j];
      m_aux = aux_en;
      m_mode = mode;
      exp_len = 4 * slen(mode);
    end else if (adv) xf++;
    if (adv) begin
      if (m_off == slen(m_mode) - 1) begin m_off = 0; m_set = (m_set + 1) % 4; end
      else m_off++;
    end
  endtask

  initial begin
    for (int j = 0; j < 4; j++) begin acc[j] = 0; alm_tag[j] = "R8"; end
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R11", out_valid, 0, "out_valid in reset");
    chk(out_sync == 0, "R11", out_sync, 0, "out_sync in reset");
    chk(es_alarm == 0, "R11", es_alarm, 0, "es_alarm in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1, "R10", out_valid, 1, "out_valid after reset");
    chk(out_sync == 1, "R11", out_sync, 1, "frame restarts at bit 0");
    // preload stores while the sink is stalled
    hold_low = 1; flood = 4'hF;
    repeat (8) step();
    hold_low = 0; flood = 0; gaps = 1;
    // phase A: 848-bit frames, tributary 3 as flag channel
    mode = 0; aux_en = 4'b1000;
    num[0] = 2053; num[1] = 2057; num[2] = 2055; num[3] = 2050; den = 8480;
    for (int i = 0; i < 2800; i++) begin
      force_ais = (i > 900 && i < 1800) ? 4'b0010 : 4'b0000;
      if (i % 50 == 0) aux_bit = aux_bit ^ 4'b1000 ^ {3'b0, i[6]};
      if (i % 300 == 0) begin alarm_bit = ~alarm_bit; national_bit = i[9]; end
      step();
    end
    // phase B: switch to 1536-bit frames in mid-frame
    mode = 1;
    num[0] = 3773; num[1] = 3777; num[2] = 3775; num[3] = 3770; den = 15360;
    for (int j = 0; j < 4; j++) acc[j] = 0;
    for (int i = 0; i < 5100; i++) begin
      if (i % 70 == 0) aux_bit = ~aux_bit;
      if (i % 400 == 0) begin alarm_bit = ~alarm_bit; national_bit = ~national_bit; end
      step();
    end
    // phase C: overflow on tributary 0, underflow on tributary 1
    mode = 0; aux_en = 0;
    num[0] = 2053; num[1] = 2057; num[2] = 2055; num[3] = 2054; den = 8480;
    flood = 4'b0001; starve = 4'b0010;
    repeat (1000) step();
    flood = 0; starve = 0;
    repeat (1000) step();
    chk(ovf_cnt > 0, "R8", ovf_cnt, 1, "overflow provoked");
    chk(udf_cnt > 0, "R9", udf_cnt, 1, "underflow provoked");
    chk(stuffed_seen > 0, "R5", stuffed_seen, 1, "stuffed frames seen");
    chk(plain_seen > 0, "R5", plain_seen, 1, "unstuffed frames seen");
    chk(len848 > 0, "R1", len848, 1, "short frames measured");
    chk(len1536 > 0, "R1", len1536, 1, "long frames measured");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule